// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block watches a running calendar and raises an alarm when the current time reaches a programmed point. It holds four alarm fields: minute, hour, day of month and day of week. Each field carries its own disable bit, so software can ask for a daily alarm (minute and hour only), a weekly one (add the weekday), a monthly one (add the date), or any other mix. All values are in BCD. The calendar counter outside the block supplies the current fields and a one-cycle strobe at every minute boundary, that is, when seconds roll over to 00. The alarm therefore resolves to the minute and never to a chosen second.

On a boundary where every enabled field equals the current value, a sticky status flag is set. An interrupt output is high while that flag and an interrupt enable bit are both set. Software programs the fields, the enable bit and the flag through a simple byte-wide write port. It can clear the flag but never set it.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the status flag and the interrupt output are 0, the interrupt enable is 0, and all four alarm fields are disabled (bit 7 = 1).
- R2: Alarm fields sit at write addresses 0x0A (minute), 0x0B (hour), 0x0C (date) and 0x0D (weekday). A field takes part in the match only while its bit 7 is 0. A disabled field's value has no effect on the match.
- R3: The status flag is set in the cycle after a clock edge where `min_tick` is 1 and every enabled field equals its current time field. When the time matches but `min_tick` is 0, the flag is not set.
- R4: The comparison uses bits 6:0 for the minute, bits 5:0 for the hour and the date, and bits 2:0 for the weekday. Current-time bits above these are ignored.
- R5: While all four fields are disabled, the status flag is never set, whatever the time.
- R6: The interrupt output equals status flag AND interrupt enable. The interrupt enable is bit 1 of address 0x00 and takes effect in the cycle after the write.
- R7: Writing address 0x01 with bit 3 = 0 clears the status flag. Writing it with bit 3 = 1 leaves the flag unchanged.
- R8: When a match and a clearing write fall on the same edge, the flag ends set.
- R9: Once set, the flag stays set through later non-matching minute boundaries until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_tick | input | 1 | One-cycle strobe at each minute boundary |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_wday | input | 8 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm status flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The checker tests the following on every cycle:
- the flag only rises after a minute strobe, and only while at least one field is enabled;
- the flag only falls after a clearing write;
- a write that turns off the interrupt enable drops the interrupt output in the next cycle.

Some behaviour can only be shown by the bench's scenarios, which compare the block with a behavioural model at every clock. This covers the per-field value comparison, the bit masking of each field and a disabled field's don't-care value. It also covers the precedence of a set over a clear on the same edge and the flag staying set across later boundaries.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   localparam int unsigned NUM_FIELDS = 4;

   // Field order matches the alarm register address order: base+0 .. base+3.
   typedef enum logic [1:0] {
      FLD_MIN  = 2'd0,
      FLD_HOUR = 2'd1,
      FLD_DATE = 2'd2,
      FLD_WDAY = 2'd3
   } field_e;

   // Bits of each field that take part in the comparison.
   function automatic logic [7:0] field_mask(input int unsigned idx);
      case (idx)
         FLD_MIN:  return 8'h7F;
         FLD_HOUR: return 8'h3F;
         FLD_DATE: return 8'h3F;
         default:  return 8'h07;
      endcase
   endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CTRL_A_ADDR = 0,
   parameter int unsigned CTRL_B_ADDR = 1,
   parameter int unsigned ALARM_BASE  = 10,
   parameter int unsigned IE_BIT      = 1,
   parameter int unsigned FLAG_BIT    = 3,
   parameter int unsigned EN_BIT      = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [DATA_W-1:0]                    wr_data,
   input  logic                                 fire,
   output logic [NUM_FIELDS-1:0][DATA_W-1:0]    alarm_reg,
   output logic                                 irq_en,
   output logic                                 flag
);

   localparam logic [DATA_W-1:0] FIELD_RST = DATA_W'(1) << EN_BIT;

   logic wr_ctrl_a;
   logic wr_ctrl_b;
   logic clear_req;

   assign wr_ctrl_a = wr_en && (wr_addr == ADDR_W'(CTRL_A_ADDR));
   assign wr_ctrl_b = wr_en && (wr_addr == ADDR_W'(CTRL_B_ADDR));
   assign clear_req = wr_ctrl_b && !wr_data[FLAG_BIT];

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      logic hit_addr;
      assign hit_addr = wr_en && (wr_addr == ADDR_W'(ALARM_BASE + gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            alarm_reg[gi] <= FIELD_RST;
         end else if (hit_addr) begin
            alarm_reg[gi] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en <= 1'b0;
      end else if (wr_ctrl_a) begin
         irq_en <= wr_data[IE_BIT];
      end
   end

   // Hardware set has priority over a software clear on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (fire) begin
         flag <= 1'b1;
      end else if (clear_req) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned EN_BIT = 7
) (
   input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_fld,
   input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_reg,
   output logic [NUM_FIELDS-1:0]             fld_en,
   output logic                              any_en,
   output logic                              all_ok
);

   logic [NUM_FIELDS-1:0] fld_ok;

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
      localparam logic [DATA_W-1:0] MASK = DATA_W'(field_mask(gi));
      logic hit;
      assign fld_en[gi] = ~alarm_reg[gi][EN_BIT];
      assign hit        = ((now_fld[gi] & MASK) == (alarm_reg[gi] & MASK));
      assign fld_ok[gi] = ~fld_en[gi] | hit;
   end

   assign any_en = |fld_en;
   assign all_ok = &fld_ok;

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cal_alarm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CTRL_A_ADDR = 0,
   parameter int unsigned CTRL_B_ADDR = 1,
   parameter int unsigned ALARM_BASE  = 10,
   parameter int unsigned IE_BIT      = 1,
   parameter int unsigned FLAG_BIT    = 3,
   parameter int unsigned EN_BIT      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              min_tick,
   input  logic [DATA_W-1:0] cur_min,
   input  logic [DATA_W-1:0] cur_hour,
   input  logic [DATA_W-1:0] cur_date,
   input  logic [DATA_W-1:0] cur_wday,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              alarm_flag,
   output logic              alarm_irq
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold a BCD byte");
   end
   if (EN_BIT >= DATA_W || IE_BIT >= DATA_W || FLAG_BIT >= DATA_W) begin : g_bad_bit
      $error("control bit positions exceed DATA_W");
   end
   if (ALARM_BASE + NUM_FIELDS > ADDR_SPAN || CTRL_A_ADDR >= ADDR_SPAN ||
       CTRL_B_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("register addresses exceed ADDR_W");
   end

   logic [NUM_FIELDS-1:0][DATA_W-1:0] now_fld;
   logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_reg;
   logic [NUM_FIELDS-1:0]             fld_en;
   logic                              any_en;
   logic                              all_ok;
   logic                              fire;
   logic                              irq_en;

   assign now_fld[FLD_MIN]  = cur_min;
   assign now_fld[FLD_HOUR] = cur_hour;
   assign now_fld[FLD_DATE] = cur_date;
   assign now_fld[FLD_WDAY] = cur_wday;

   cal_alarm_cmp #(
      .DATA_W (DATA_W),
      .EN_BIT (EN_BIT)
   ) i_cmp (
      .now_fld   (now_fld),
      .alarm_reg (alarm_reg),
      .fld_en    (fld_en),
      .any_en    (any_en),
      .all_ok    (all_ok)
   );

   assign fire = min_tick & any_en & all_ok;

   cal_alarm_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CTRL_A_ADDR (CTRL_A_ADDR),
      .CTRL_B_ADDR (CTRL_B_ADDR),
      .ALARM_BASE  (ALARM_BASE),
      .IE_BIT      (IE_BIT),
      .FLAG_BIT    (FLAG_BIT),
      .EN_BIT      (EN_BIT)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fire      (fire),
      .alarm_reg (alarm_reg),
      .irq_en    (irq_en),
      .flag      (alarm_flag)
   );

   assign alarm_irq = alarm_flag & irq_en;

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NFLD        = 4,
   parameter int unsigned CTRL_A_ADDR = 0,
   parameter int unsigned CTRL_B_ADDR = 1,
   parameter int unsigned IE_BIT      = 1,
   parameter int unsigned FLAG_BIT    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              min_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [NFLD-1:0]   fld_en,
   input logic              alarm_flag,
   input logic              alarm_irq
);

   logic clr_wr;
   logic ie_off_wr;
   assign clr_wr    = wr_en && (wr_addr == ADDR_W'(CTRL_B_ADDR)) && !wr_data[FLAG_BIT];
   assign ie_off_wr = wr_en && (wr_addr == ADDR_W'(CTRL_A_ADDR)) && !wr_data[IE_BIT];

   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(min_tick)); // R3

   AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(|fld_en)); // R5

   AST_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_flag) |-> $past(clr_wr)); // R7

   AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ie_off_wr |=> !alarm_irq); // R6

endmodule

bind cal_alarm_match cal_alarm_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NFLD        (cal_alarm_pkg::NUM_FIELDS),
   .CTRL_A_ADDR (CTRL_A_ADDR),
   .CTRL_B_ADDR (CTRL_B_ADDR),
   .IE_BIT      (IE_BIT),
   .FLAG_BIT    (FLAG_BIT)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .min_tick   (min_tick),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .fld_en     (fld_en),
   .alarm_flag (alarm_flag),
   .alarm_irq  (alarm_irq)
);

// File: tb/test_cal_alarm_match.sv
`timescale 1ns/1ps
module test_cal_alarm_match;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       min_tick = 1'b0;
   logic [7:0] cur_min = 8'h00;
   logic [7:0] cur_hour = 8'h00;
   logic [7:0] cur_date = 8'h00;
   logic [7:0] cur_wday = 8'h00;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = 5'd0;
   logic [7:0] wr_data = 8'h00;
   logic       alarm_flag;
   logic       alarm_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   cal_alarm_match i_cal_alarm_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .min_tick   (min_tick),
      .cur_min    (cur_min),
      .cur_hour   (cur_hour),
      .cur_date   (cur_date),
      .cur_wday   (cur_wday),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .alarm_flag (alarm_flag),
      .alarm_irq  (alarm_irq)
   );

   // Behavioural reference model
   logic [7:0] m_reg [4];
   logic [7:0] m_now [4];
   logic [7:0] m_mask [4];
   bit         m_af, m_aie, m_any, m_ok;

   initial begin
      m_mask[0] = 8'h7F; m_mask[1] = 8'h3F; m_mask[2] = 8'h3F; m_mask[3] = 8'h07;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_reg[i] = 8'h80;
         m_af = 0; m_aie = 0;
      end else begin
         m_now[0] = cur_min; m_now[1] = cur_hour; m_now[2] = cur_date; m_now[3] = cur_wday;
         m_any = 0; m_ok = 1;
         for (int i = 0; i < 4; i++) begin
            if (!m_reg[i][7]) begin
               m_any = 1;
               if ((m_now[i] & m_mask[i]) != (m_reg[i] & m_mask[i])) m_ok = 0;
            end
         end
         if (min_tick && m_any && m_ok) m_af = 1;
         else if (wr_en && wr_addr == 5'd1 && !wr_data[3]) m_af = 0;
         if (wr_en && wr_addr == 5'd0) m_aie = wr_data[1];
         if (wr_en && wr_addr >= 5'd10 && wr_addr <= 5'd13) m_reg[wr_addr - 5'd10] = wr_data;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Per-cycle comparison with the model, away from the edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(alarm_flag == m_af, "R3 model flag", int'(alarm_flag), int'(m_af));
         check(alarm_irq == (m_af & m_aie), "R6 model irq", int'(alarm_irq), int'(m_af & m_aie));
      end
   end

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] mi, input logic [7:0] hr,
                           input logic [7:0] dt, input logic [7:0] wd);
      cur_min = mi; cur_hour = hr; cur_date = dt; cur_wday = wd;
   endtask

   task automatic tick(input logic [7:0] mi, input logic [7:0] hr,
                       input logic [7:0] dt, input logic [7:0] wd);
      @(negedge clk);
      set_time(mi, hr, dt, wd);
      min_tick = 1'b1;
      @(negedge clk);
      min_tick = 1'b0;
   endtask

   task automatic tick_and_clear(input logic [7:0] mi, input logic [7:0] hr,
                                 input logic [7:0] dt, input logic [7:0] wd);
      @(negedge clk);
      set_time(mi, hr, dt, wd);
      min_tick = 1'b1;
      wr_en = 1'b1; wr_addr = 5'd1; wr_data = 8'h00;
      @(negedge clk);
      min_tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic final_report();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         check(1'b0, "R3 watchdog expired", 0, 1);
         final_report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(alarm_flag == 1'b0, "R1 flag after reset", int'(alarm_flag), 0);
      check(alarm_irq == 1'b0, "R1 irq after reset", int'(alarm_irq), 0);
      tick(8'h00, 8'h00, 8'h00, 8'h00);
      check(alarm_flag == 1'b0, "R1 fields disabled after reset", int'(alarm_flag), 0);

      // R3: minute alarm at 0x30
      wr(5'd10, 8'h30);
      tick(8'h29, 8'h00, 8'h01, 8'h00);
      check(alarm_flag == 1'b0, "R3 no match at 29", int'(alarm_flag), 0);
      @(negedge clk); set_time(8'h30, 8'h00, 8'h01, 8'h00);
      repeat (3) @(negedge clk);
      check(alarm_flag == 1'b0, "R3 match without strobe", int'(alarm_flag), 0);
      tick(8'h30, 8'h00, 8'h01, 8'h00);
      check(alarm_flag == 1'b1, "R3 match on strobe", int'(alarm_flag), 1);
      check(alarm_irq == 1'b0, "R6 irq masked", int'(alarm_irq), 0);
      wr(5'd0, 8'h02);
      check(alarm_irq == 1'b1, "R6 irq enabled", int'(alarm_irq), 1);

      // R9: sticky across non-matching boundary
      tick(8'h31, 8'h00, 8'h01, 8'h00);
      check(alarm_flag == 1'b1, "R9 flag sticky", int'(alarm_flag), 1);

      // R7: write 1 keeps, write 0 clears
      wr(5'd1, 8'h08);
      check(alarm_flag == 1'b1, "R7 write one ignored", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);
      check(alarm_flag == 1'b0, "R7 write zero clears", int'(alarm_flag), 0);
      check(alarm_irq == 1'b0, "R6 irq follows flag", int'(alarm_irq), 0);

      // R4: minute upper bit ignored
      tick(8'hB0, 8'h00, 8'h01, 8'h00);
      check(alarm_flag == 1'b1, "R4 minute bit7 ignored", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);

      // R2/R4: minute + hour, hour upper bits ignored
      wr(5'd11, 8'h12);
      tick(8'h30, 8'hD2, 8'h01, 8'h00);
      check(alarm_flag == 1'b1, "R4 hour bits 7:6 ignored", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);
      tick(8'h30, 8'h13, 8'h01, 8'h00);
      check(alarm_flag == 1'b0, "R2 hour mismatch blocks", int'(alarm_flag), 0);

      // R2: weekday only, minute field disabled with any value
      wr(5'd10, 8'hFF);
      wr(5'd11, 8'h80);
      wr(5'd13, 8'h05);
      tick(8'h00, 8'h07, 8'h22, 8'h05);
      check(alarm_flag == 1'b1, "R2 weekday only match", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);
      tick(8'h00, 8'h07, 8'h22, 8'h0D);
      check(alarm_flag == 1'b1, "R4 weekday bit3 ignored", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);

      // R2: date field
      wr(5'd12, 8'h15);
      tick(8'h00, 8'h00, 8'h16, 8'h05);
      check(alarm_flag == 1'b0, "R2 date mismatch blocks", int'(alarm_flag), 0);
      tick(8'h00, 8'h00, 8'h15, 8'h05);
      check(alarm_flag == 1'b1, "R2 date and weekday match", int'(alarm_flag), 1);

      // R8: set wins over same-edge clear
      wr(5'd1, 8'h00);
      tick_and_clear(8'h00, 8'h00, 8'h15, 8'h05);
      check(alarm_flag == 1'b1, "R8 set beats clear", int'(alarm_flag), 1);
      wr(5'd1, 8'h00);

      // R5: all disabled never fires
      wr(5'd12, 8'h95);
      wr(5'd13, 8'h85);
      tick(8'h00, 8'h00, 8'h15, 8'h05);
      check(alarm_flag == 1'b0, "R5 all disabled, equal time", int'(alarm_flag), 0);
      tick(8'h59, 8'h23, 8'h31, 8'h06);
      check(alarm_flag == 1'b0, "R5 all disabled, other time", int'(alarm_flag), 0);

      // R6: enable off drops irq while flag set
      wr(5'd10, 8'h45);
      tick(8'h45, 8'h00, 8'h01, 8'h00);
      check(alarm_irq == 1'b1, "R6 irq with flag and enable", int'(alarm_irq), 1);
      wr(5'd0, 8'h00);
      check(alarm_irq == 1'b0, "R6 irq off after enable cleared", int'(alarm_irq), 0);
      check(alarm_flag == 1'b1, "R6 flag kept when enable cleared", int'(alarm_flag), 1);

      repeat (2) @(negedge clk);
      final_report();
   end

endmodule